// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Reconfiguration

This block drives four independent pulse-width modulated outputs from one clock. Each channel is set up through two 32-bit words on a small memory-mapped register port: a write uses an address, write data and a one-cycle write strobe, and a read returns data combinationally from the address. A channel divides the input clock by a prescaler and then counts prescaled ticks up to a period divider. Its output is high for the first part of each period, for a programmable number of prescaled ticks.

New divider and high-time values are first held as staged settings. They reach the running counters only when software sets a self-clearing update flag. The counters take the staged values at the next period boundary, so no output period is ever made from a mix of old and new settings. When a channel is disabled, it finishes the period it is in, drives its pin low, and restores the two divider fields to fixed idle values.

The register port carries no data stream, so it has no valid/ready handshake. A write always completes in the cycle its strobe is sampled.

Top module: `pwm_quad`

## Requirements
- R1: Channel i has a low word at byte address 8*i and a high word at 8*i+4. The low word holds the period divider in bits 15:0 and the high-time count in bits 31:16. The high word holds the prescaler in bits 15:0, the update flag in bit 30 and the enable flag in bit 31, and its other bits read zero. Reads return the staged values. After reset every low word reads 0x00000001 and every high word reads 0.
- R2: While running with prescaler P, divider D and high count H, a period lasts (P+1)*(D+1) clocks. The output is high during the first H*(P+1) clocks of each period.
- R3: If H*(P+1) is at least the period length, the output stays high for the whole period. H=0 keeps the output low.
- R4: A write that sets enable and update on an idle channel loads the staged values. The first period starts on the clock after the write is sampled.
- R5: Setting update while a channel runs lets the current period finish with the old values. The new values apply from the next period on.
- R6: The update flag reads 1 while a commit is pending and clears by itself once the staged values are loaded.
- R7: Clearing enable lets the current period run to its end. After that the output stays low.
- R8: Once a disable has completed, the prescaler reads 0x0000 and the divider reads 0x0001. The high-time count is kept.
- R9: A write to an unmapped or misaligned address changes no register. A read of such an address returns zero.
- R10: Channels are independent. Setting up or running one channel does not affect the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pwm_out | output | NCH | One modulated output per channel |

## Verification
The main test sweeps prescaler 0..2, divider 0..3 and high count 0..5 across rotating channels. Every output cycle of two periods is compared with the arithmetic waveform. This covers period length, high time, and the 0% and 100% saturation cases. It also shows that the first period begins exactly one clock after the enabling write. A mid-period change of all three fields separates a boundary-aligned commit from an immediate one. A mid-period disable separates an orderly stop from an abrupt one and checks the restored divider fields. Two channels started two cycles apart with different settings show that channels stay independent.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int FIELD_W = 16;
  localparam int BIT_UPD = 30;
  localparam int BIT_EN  = 31;
  localparam logic [FIELD_W-1:0] PRE_IDLE = '0;
  localparam logic [FIELD_W-1:0] DIV_IDLE = FIELD_W'(1);

  typedef struct packed {
    logic [FIELD_W-1:0] pre;
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] hi;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        commit,
  input  logic        stop_done,
  output pwm_cfg_t    stg,
  output logic        en,
  output logic        upd,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg.pre <= PRE_IDLE;
      stg.div <= DIV_IDLE;
      stg.hi  <= '0;
      en      <= 1'b0;
      upd     <= 1'b0;
    end else begin
      if (wr_lo) begin
        stg.div <= wdata[FIELD_W-1:0];
        stg.hi  <= wdata[16 +: FIELD_W];
      end else if (stop_done) begin
        stg.div <= DIV_IDLE;
      end
      if (wr_hi) begin
        stg.pre <= wdata[FIELD_W-1:0];
        en      <= wdata[BIT_EN];
      end else if (stop_done) begin
        stg.pre <= PRE_IDLE;
      end
      if (wr_hi && wdata[BIT_UPD]) upd <= 1'b1;
      else if (commit)             upd <= 1'b0;
    end
  end

  always_comb begin
    rd_lo = '0;
    rd_lo[FIELD_W-1:0]   = stg.div;
    rd_lo[16 +: FIELD_W] = stg.hi;
    rd_hi = '0;
    rd_hi[FIELD_W-1:0] = stg.pre;
    rd_hi[BIT_UPD]     = upd;
    rd_hi[BIT_EN]      = en;
  end

  AST_UPD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_hi && wdata[BIT_UPD])) |=> !upd); // R6
  AST_STOP_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && !wr_lo && !wr_hi) |=> (stg.pre == PRE_IDLE && stg.div == DIV_IDLE)); // R8
endmodule

// File: rtl/pwm_quad_core.sv
module pwm_quad_core
  import pwm_quad_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     upd,
  input  pwm_cfg_t stg,
  output logic     commit,
  output logic     stop_done,
  output logic     pwm_o
);
  pwm_cfg_t           act;
  logic               running;
  logic [FIELD_W-1:0] pre_cnt;
  logic [FIELD_W-1:0] div_cnt;
  logic               period_end;
  logic               start;

  assign period_end = running && (pre_cnt == act.pre) && (div_cnt == act.div);
  assign start      = !running && en;
  assign commit     = upd && en && (start || period_end);
  assign stop_done  = period_end && !en;
  assign pwm_o      = running && (div_cnt < act.hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_cnt <= '0;
      div_cnt <= '0;
      act.pre <= PRE_IDLE;
      act.div <= DIV_IDLE;
      act.hi  <= '0;
    end else begin
      if (commit) act <= stg;
      if (start) begin
        running <= 1'b1;
        pre_cnt <= '0;
        div_cnt <= '0;
      end else if (period_end) begin
        pre_cnt <= '0;
        div_cnt <= '0;
        if (!en) running <= 1'b0;
      end else if (running) begin
        if (pre_cnt == act.pre) begin
          pre_cnt <= '0;
          div_cnt <= div_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pre_cnt <= act.pre && div_cnt <= act.div)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_end) |=> $stable(act)); // R5
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(period_end)); // R7
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (pre_cnt == '0 && div_cnt == '0)); // R4
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wen,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [31:0]      rd_lo [NCH];
  logic [31:0]      rd_hi [NCH];

  assign idx = bus_addr[ADDR_W-1:3];
  assign hit = (bus_addr[1:0] == 2'b00) &&
               ({{(32-IDX_W){1'b0}}, idx} < 32'(NCH));

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic     sel, commit, stop_done, en, upd;
    pwm_cfg_t stg;

    assign sel = bus_wen && hit && (idx == IDX_W'(gi));

    pwm_quad_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (sel && !bus_addr[2]),
      .wr_hi     (sel && bus_addr[2]),
      .wdata     (bus_wdata),
      .commit    (commit),
      .stop_done (stop_done),
      .stg       (stg),
      .en        (en),
      .upd       (upd),
      .rd_lo     (rd_lo[gi]),
      .rd_hi     (rd_hi[gi])
    );

    pwm_quad_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .upd       (upd),
      .stg       (stg),
      .commit    (commit),
      .stop_done (stop_done),
      .pwm_o     (pwm_out[gi])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit && idx == IDX_W'(i)) bus_rdata = bus_addr[2] ? rd_hi[i] : rd_lo[i];
    end
  end
endmodule

// File: tb/pwm_quad_tb_top.sv
module pwm_quad_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_wen = 1'b0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    pwm_out;

  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] obs [0:63];

  pwm_quad #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wen(bus_wen), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expv(int k, int p, int d, int h);
    int per = (p + 1) * (d + 1);
    return ((k % per) / (p + 1)) < h;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_wen = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  task automatic capture(input int n, input int k0, input int a0, input logic [31:0] d0,
                         input int k1, input int a1, input logic [31:0] d1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      obs[k] = pwm_out;
      bus_wen = 1'b0;
      if (k == k0) begin bus_addr = ADDR_W'(a0); bus_wdata = d0; bus_wen = 1'b1; end
      if (k == k1) begin bus_addr = ADDR_W'(a1); bus_wdata = d1; bus_wen = 1'b1; end
    end
    bus_wen = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int mism;

    // R1: reset state
    do_reset();
    #1 check(pwm_out == '0, "R1 reset outputs", 32'(pwm_out), 0);
    bus_read(0, rd);  check(rd == 32'h0000_0001, "R1 reset low word", rd, 32'h0000_0001);
    bus_read(4, rd);  check(rd == 32'h0, "R1 reset high word", rd, 0);

    // R2 R3 R4 sweep
    for (int p = 0; p <= 2; p++)
      for (int d = 0; d <= 3; d++)
        for (int h = 0; h <= 5; h++) begin
          int ch = (p + d + h) % NCH;
          int per = (p + 1) * (d + 1);
          do_reset();
          bus_write(ch*8, {16'(h), 16'(d)});
          bus_write(ch*8+4, 32'hC000_0000 | 32'(p));
          capture(2*per, -1, 0, 0, -1, 0, 0);
          mism = 0;
          for (int k = 0; k < 2*per; k++)
            for (int c = 0; c < NCH; c++)
              if (obs[k][c] !== ((c == ch) ? expv(k, p, d, h) : 1'b0)) mism++;
          check(mism == 0, "R2 R3 R4 waveform", 32'(mism), 0);
          bus_read(ch*8, rd);
          check(rd == {16'(h), 16'(d)}, "R1 staged low word", rd, {16'(h), 16'(d)});
          bus_read(ch*8+4, rd);
          check(rd == (32'h8000_0000 | 32'(p)), "R6 update cleared", rd, 32'h8000_0000 | 32'(p));
        end

    // R6 pending flag, R1 staged readback
    do_reset();
    bus_write(16, {16'd5, 16'd9});
    bus_write(20, 32'hC000_0003);
    bus_write(16, {16'd2, 16'd4});
    bus_write(20, 32'hC000_0000);
    bus_read(20, rd); check(rd == 32'hC000_0000, "R6 pending visible", rd, 32'hC000_0000);
    bus_read(16, rd); check(rd == {16'd2, 16'd4}, "R1 staged not active", rd, {16'd2, 16'd4});
    repeat (45) @(posedge clk);
    bus_read(20, rd); check(rd == 32'h8000_0000, "R6 cleared after commit", rd, 32'h8000_0000);

    // R9 unmapped and misaligned
    bus_write(32, 32'hFFFF_FFFF);
    bus_write(1, 32'hFFFF_FFFF);
    bus_write(21, 32'h0000_0000);
    bus_read(32, rd); check(rd == 0, "R9 unmapped reads zero", rd, 0);
    bus_read(1, rd);  check(rd == 0, "R9 misaligned reads zero", rd, 0);
    bus_read(0, rd);  check(rd == 32'h0000_0001, "R9 ch0 untouched", rd, 32'h0000_0001);
    bus_read(20, rd); check(rd == 32'h8000_0000, "R9 ch2 untouched", rd, 32'h8000_0000);

    // R5 boundary commit
    do_reset();
    bus_write(0, {16'd2, 16'd3});
    bus_write(4, 32'hC000_0001);
    capture(18, 2, 0, {16'd3, 16'd4}, 4, 4, 32'hC000_0000);
    mism = 0;
    for (int k = 0; k < 18; k++)
      if (obs[k][0] !== ((k < 8) ? expv(k, 1, 3, 2) : expv(k - 8, 0, 4, 3))) mism++;
    check(mism == 0, "R5 commit at boundary", 32'(mism), 0);

    // R7 orderly stop, R8 idle fields
    do_reset();
    bus_write(24, {16'd2, 16'd2});
    bus_write(28, 32'hC000_0001);
    capture(14, 3, 28, 32'h0000_0001, -1, 0, 0);
    mism = 0;
    for (int k = 0; k < 14; k++)
      if (obs[k][3] !== ((k < 6) ? expv(k, 1, 2, 2) : 1'b0)) mism++;
    check(mism == 0, "R7 finish then low", 32'(mism), 0);
    bus_read(28, rd); check(rd == 32'h0, "R8 prescaler idle", rd, 0);
    bus_read(24, rd); check(rd == 32'h0002_0001, "R8 divider idle", rd, 32'h0002_0001);
    bus_write(28, 32'hC000_0000);
    capture(6, -1, 0, 0, -1, 0, 0);
    mism = 0;
    for (int k = 0; k < 6; k++) if (obs[k][3] !== 1'b1) mism++;
    check(mism == 0, "R3 R4 restart full duty", 32'(mism), 0);

    // R10 independence
    do_reset();
    bus_write(24, {16'd3, 16'd1});
    bus_write(8,  {16'd1, 16'd2});
    bus_write(12, 32'hC000_0000);
    bus_write(28, 32'hC000_0001);
    capture(12, -1, 0, 0, -1, 0, 0);
    mism = 0;
    for (int k = 0; k < 12; k++) begin
      if (obs[k][1] !== expv(k + 2, 0, 2, 1)) mism++;
      if (obs[k][3] !== expv(k, 1, 1, 3)) mism++;
      if (obs[k][0] !== 1'b0 || obs[k][2] !== 1'b0) mism++;
    end
    check(mism == 0, "R10 channels independent", 32'(mism), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule